// File: doc/BRIEF.md
# Pairwise True-LRU Way Selector

This block holds the recency order of the ways in one set of a set-associative cache. It uses one flag for each pair of ways. Each flag records which member of its pair was used less recently. From the flags the block names the way to evict on a miss. The cache controller pulses a touch strobe with a way index on every hit or fill. Software can overwrite the flags directly through a load port.

The default configuration has four ways and therefore six flags. A way is the victim when it is older than every other way. Only flag patterns that form a consistent total order are legal. Any other pattern raises an error output, and the victim then falls back to way 0. A power-on reset clears the flags. A separate manual reset leaves the flags untouched and freezes them while it is held.

Top module: `lru_pair_sel`

## Requirements
- R1: While `por_rst_n` is low at a rising clock edge, the state is cleared to 6'b000000. After that edge `state_o` reads 0, `victim_o` reads 3 and `illegal_o` reads 0.
- R2: While `man_rst` is high at a clock edge, the state keeps its value, and any touch or load in that cycle is ignored.
- R3: When `sw_wr_i` is high, `state_o` equals `sw_data_i` after the next edge. This holds even when `touch_i` is high in the same cycle.
- R4: Flag positions: bit5 compares ways 0/1, bit4 ways 0/2, bit3 ways 0/3, bit2 ways 1/2, bit1 ways 1/3 and bit0 ways 2/3. A flag value of 1 means the lower-numbered way of its pair is the older one. A touch of way w with no load clears each flag where w is the lower way and sets each flag where w is the higher way. All other flags are left alone.
- R5: For a legal state, `victim_o` is the one way that is older than all three others.
- R6: A state is legal when its flags describe one of the 24 strict orders of four ways. For an illegal state, `illegal_o` is 1 and `victim_o` is 0. For a legal state, `illegal_o` is 0.
- R7: With no touch and no load, the state holds.
- R8: A touch of way w on a legal state leaves a legal state whose victim is not w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on reset, active low, synchronous |
| man_rst | input | 1 | Manual reset, active high; freezes the state |
| touch_i | input | 1 | Access strobe |
| touch_way_i | input | 2 | Way that was accessed |
| sw_wr_i | input | 1 | Software load strobe |
| sw_data_i | input | 6 | Value to load into the flags |
| victim_o | output | 2 | Way to replace |
| state_o | output | 6 | Current flag register |
| illegal_o | output | 1 | State is not a consistent order |

## Verification
The flag register is the only register between a stimulus and `state_o`. A touch, load or reset applied before an edge shows up on `state_o` just after that edge. `victim_o` and `illegal_o` are decoded from that register without further delay, so they change in the same cycle as `state_o`. The bench drives inputs on the falling edge and samples one time unit after the following rising edge. For the idle and manual-reset cases it samples again after further edges to confirm that nothing moved.

// File: rtl/lru_pair_pkg.sv
package lru_pair_pkg;
   // Lexicographic index of the pair (i,j), i<j, among n ways.
   function automatic int pair_index(input int i, input int j, input int n);
      return (i * (2 * n - i - 1)) / 2 + (j - i - 1);
   endfunction

   // Bit position of pair (i,j): the first pair sits in the top bit.
   function automatic int pair_bit(input int i, input int j, input int n);
      return (n * (n - 1)) / 2 - 1 - pair_index(i, j, n);
   endfunction
endpackage

// File: rtl/lru_touch_next.sv
module lru_touch_next #(
   parameter int NUM_WAYS = 4,
   localparam int WW = $clog2(NUM_WAYS),
   localparam int PB = NUM_WAYS * (NUM_WAYS - 1) / 2
) (
   input  logic [PB-1:0] cur_i,
   input  logic [WW-1:0] way_i,
   output logic [PB-1:0] nxt_o
);
   import lru_pair_pkg::*;

   always_comb begin
      nxt_o = cur_i;
      for (int i = 0; i < NUM_WAYS; i++) begin
         for (int j = i + 1; j < NUM_WAYS; j++) begin
            if (way_i == WW'(i))      nxt_o[pair_bit(i, j, NUM_WAYS)] = 1'b0;
            else if (way_i == WW'(j)) nxt_o[pair_bit(i, j, NUM_WAYS)] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/lru_victim_dec.sv
module lru_victim_dec #(
   parameter int NUM_WAYS     = 4,
   parameter int FALLBACK_WAY = 0,
   localparam int WW = $clog2(NUM_WAYS),
   localparam int PB = NUM_WAYS * (NUM_WAYS - 1) / 2
) (
   input  logic [PB-1:0] state_i,
   output logic [WW-1:0] victim_o,
   output logic          illegal_o
);
   import lru_pair_pkg::*;

   logic [NUM_WAYS-1:0][WW-1:0] older_cnt;
   logic [NUM_WAYS-1:0]         rank_seen;

   for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rank
      always_comb begin
         older_cnt[w] = '0;
         for (int o = 0; o < NUM_WAYS; o++) begin
            if (o > w && state_i[pair_bit(w, o, NUM_WAYS)])
               older_cnt[w] = older_cnt[w] + 1'b1;
            else if (o < w && !state_i[pair_bit(o, w, NUM_WAYS)])
               older_cnt[w] = older_cnt[w] + 1'b1;
         end
      end
   end

   always_comb begin
      rank_seen = '0;
      victim_o  = WW'(FALLBACK_WAY);
      for (int w = 0; w < NUM_WAYS; w++) rank_seen[older_cnt[w]] = 1'b1;
      illegal_o = ~&rank_seen;
      if (!illegal_o) begin
         for (int w = 0; w < NUM_WAYS; w++)
            if (older_cnt[w] == WW'(NUM_WAYS - 1)) victim_o = WW'(w);
      end
   end
endmodule

// File: rtl/lru_state_reg.sv
module lru_state_reg #(
   parameter int PB = 6
) (
   input  logic          clk,
   input  logic          por_rst_n,
   input  logic          man_rst,
   input  logic          touch_i,
   input  logic [PB-1:0] touch_nxt_i,
   input  logic          sw_wr_i,
   input  logic [PB-1:0] sw_data_i,
   output logic [PB-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (!por_rst_n)         q_o <= '0;
      else if (!man_rst) begin
         if (sw_wr_i)         q_o <= sw_data_i;
         else if (touch_i)    q_o <= touch_nxt_i;
      end
   end
endmodule

// File: rtl/lru_pair_sel.sv
module lru_pair_sel #(
   parameter int NUM_WAYS     = 4,
   parameter int FALLBACK_WAY = 0,
   localparam int WW = $clog2(NUM_WAYS),
   localparam int PB = NUM_WAYS * (NUM_WAYS - 1) / 2
) (
   input  logic          clk,
   input  logic          por_rst_n,
   input  logic          man_rst,
   input  logic          touch_i,
   input  logic [WW-1:0] touch_way_i,
   input  logic          sw_wr_i,
   input  logic [PB-1:0] sw_data_i,
   output logic [WW-1:0] victim_o,
   output logic [PB-1:0] state_o,
   output logic          illegal_o
);
   if (NUM_WAYS < 2 || NUM_WAYS > 8 || (1 << WW) != NUM_WAYS) begin : g_bad_ways
      $error("lru_pair_sel: NUM_WAYS must be a power of two in 2..8");
   end
   if (FALLBACK_WAY < 0 || FALLBACK_WAY >= NUM_WAYS) begin : g_bad_fb
      $error("lru_pair_sel: FALLBACK_WAY out of range");
   end

   logic [PB-1:0] touch_nxt;

   lru_touch_next #(.NUM_WAYS(NUM_WAYS)) u_next (
      .cur_i(state_o), .way_i(touch_way_i), .nxt_o(touch_nxt)
   );

   lru_state_reg #(.PB(PB)) u_reg (
      .clk(clk), .por_rst_n(por_rst_n), .man_rst(man_rst),
      .touch_i(touch_i), .touch_nxt_i(touch_nxt),
      .sw_wr_i(sw_wr_i), .sw_data_i(sw_data_i), .q_o(state_o)
   );

   lru_victim_dec #(.NUM_WAYS(NUM_WAYS), .FALLBACK_WAY(FALLBACK_WAY)) u_dec (
      .state_i(state_o), .victim_o(victim_o), .illegal_o(illegal_o)
   );
endmodule

// File: rtl/lru_pair_sel_chk.sv
module lru_pair_sel_chk #(
   parameter int NUM_WAYS     = 4,
   parameter int FALLBACK_WAY = 0,
   localparam int WW = $clog2(NUM_WAYS),
   localparam int PB = NUM_WAYS * (NUM_WAYS - 1) / 2
) (
   input logic          clk,
   input logic          por_rst_n,
   input logic          man_rst,
   input logic          touch_i,
   input logic [WW-1:0] touch_way_i,
   input logic          sw_wr_i,
   input logic [PB-1:0] sw_data_i,
   input logic [WW-1:0] victim_o,
   input logic [PB-1:0] state_o,
   input logic          illegal_o
);
   AST_POR_CLEARS: assert property (@(posedge clk) disable iff (!por_rst_n)
      $rose(por_rst_n) |-> state_o == '0);                                   // R1
   AST_MANUAL_FREEZE: assert property (@(posedge clk) disable iff (!por_rst_n)
      man_rst |=> $stable(state_o));                                         // R2
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!por_rst_n)
      (sw_wr_i && !man_rst) |=> state_o == $past(sw_data_i));                // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!por_rst_n)
      (!sw_wr_i && !touch_i) |=> $stable(state_o));                          // R7
   AST_FALLBACK: assert property (@(posedge clk) disable iff (!por_rst_n)
      illegal_o |-> victim_o == WW'(FALLBACK_WAY));                          // R6
   AST_TOUCH_KEEPS_ORDER: assert property (@(posedge clk) disable iff (!por_rst_n)
      (touch_i && !sw_wr_i && !man_rst && !illegal_o)
      |=> (!illegal_o && victim_o != $past(touch_way_i)));                   // R8
endmodule

bind lru_pair_sel lru_pair_sel_chk #(.NUM_WAYS(NUM_WAYS), .FALLBACK_WAY(FALLBACK_WAY)) u_chk (
   .clk(clk), .por_rst_n(por_rst_n), .man_rst(man_rst), .touch_i(touch_i),
   .touch_way_i(touch_way_i), .sw_wr_i(sw_wr_i), .sw_data_i(sw_data_i),
   .victim_o(victim_o), .state_o(state_o), .illegal_o(illegal_o)
);

// File: tb/tb_lru_pair_sel.sv
module tb_lru_pair_sel;
   logic       clk = 1'b0;
   logic       por_rst_n = 1'b0;
   logic       man_rst = 1'b0;
   logic       touch_i = 1'b0;
   logic [1:0] touch_way_i = '0;
   logic       sw_wr_i = 1'b0;
   logic [5:0] sw_data_i = '0;
   logic [1:0] victim_o;
   logic [5:0] state_o;
   logic       illegal_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   lru_pair_sel dut (
      .clk(clk), .por_rst_n(por_rst_n), .man_rst(man_rst), .touch_i(touch_i),
      .touch_way_i(touch_way_i), .sw_wr_i(sw_wr_i), .sw_data_i(sw_data_i),
      .victim_o(victim_o), .state_o(state_o), .illegal_o(illegal_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Flag position for pair (i,j), i<j, as stated in R4.
   function automatic int fpos(input int i, input int j);
      if (i == 0 && j == 1) return 5;
      if (i == 0 && j == 2) return 4;
      if (i == 0 && j == 3) return 3;
      if (i == 1 && j == 2) return 2;
      if (i == 1 && j == 3) return 1;
      return 0;
   endfunction

   // Search all 24 orders for one whose flags equal p; returns oldest way or -1.
   function automatic int order_oldest(input logic [5:0] p);
      int ages[4];
      logic [5:0] pat;
      for (int a = 0; a < 4; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++)
               for (int d = 0; d < 4; d++) begin
                  if (a != b && a != c && a != d && b != c && b != d && c != d) begin
                     ages[0] = a; ages[1] = b; ages[2] = c; ages[3] = d;
                     pat = '0;
                     for (int i = 0; i < 4; i++)
                        for (int j = i + 1; j < 4; j++)
                           pat[fpos(i, j)] = (ages[i] > ages[j]);
                     if (pat == p) begin
                        for (int w = 0; w < 4; w++) if (ages[w] == 3) return w;
                     end
                  end
               end
      return -1;
   endfunction

   function automatic logic [5:0] after_touch(input logic [5:0] p, input int w);
      logic [5:0] r = p;
      for (int i = 0; i < 4; i++)
         for (int j = i + 1; j < 4; j++) begin
            if (i == w) r[fpos(i, j)] = 1'b0;
            else if (j == w) r[fpos(i, j)] = 1'b1;
         end
      return r;
   endfunction

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic load(input logic [5:0] v);
      @(negedge clk);
      sw_wr_i = 1'b1; sw_data_i = v;
      step();
      @(negedge clk);
      sw_wr_i = 1'b0;
   endtask

   task automatic touch(input int w);
      @(negedge clk);
      touch_i = 1'b1; touch_way_i = 2'(w);
      step();
      @(negedge clk);
      touch_i = 1'b0;
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 state", int'(state_o), 0);
      chk("R1 victim", int'(victim_o), 3);
      chk("R1 illegal", int'(illegal_o), 0);
      @(negedge clk) por_rst_n = 1'b1;

      // Load sweep over all 64 values
      for (int p = 0; p < 64; p++) begin
         int ov;
         load(6'(p));
         ov = order_oldest(6'(p));
         chk("R3 load", int'(state_o), p);
         chk("R6 illegal flag", int'(illegal_o), (ov < 0) ? 1 : 0);
         chk("R5 victim", int'(victim_o), (ov < 0) ? 0 : ov);
      end

      // Touch sweep from every value and every way
      for (int p = 0; p < 64; p++) begin
         for (int w = 0; w < 4; w++) begin
            logic [5:0] e;
            int ov;
            load(6'(p));
            touch(w);
            e = after_touch(6'(p), w);
            ov = order_oldest(e);
            chk("R4 touch update", int'(state_o), int'(e));
            chk("R6 victim after touch", int'(victim_o), (ov < 0) ? 0 : ov);
            if (order_oldest(6'(p)) >= 0) begin
               chk("R8 legal kept", int'(illegal_o), 0);
               chk("R8 not touched way", int'(victim_o != 2'(w)), 1);
            end
         end
      end

      // Idle hold
      load(6'b010110);
      repeat (3) step();
      chk("R7 idle hold", int'(state_o), 6'b010110);
      chk("R7 victim hold", int'(victim_o), 1);

      // Load and touch together: load wins
      @(negedge clk);
      sw_wr_i = 1'b1; sw_data_i = 6'b111000; touch_i = 1'b1; touch_way_i = 2'd0;
      step();
      @(negedge clk);
      sw_wr_i = 1'b0; touch_i = 1'b0;
      chk("R3 load beats touch", int'(state_o), 6'b111000);
      chk("R3 victim", int'(victim_o), 0);

      // Manual reset freezes state and ignores strobes
      load(6'b001011);
      @(negedge clk);
      man_rst = 1'b1; sw_wr_i = 1'b1; sw_data_i = 6'b000000;
      step();
      chk("R2 load ignored", int'(state_o), 6'b001011);
      @(negedge clk);
      sw_wr_i = 1'b0; touch_i = 1'b1; touch_way_i = 2'd2;
      step();
      chk("R2 touch ignored", int'(state_o), 6'b001011);
      chk("R2 victim", int'(victim_o), 2);
      @(negedge clk);
      man_rst = 1'b0; touch_i = 1'b0;
      step();
      chk("R2 after release", int'(state_o), 6'b001011);

      // Power-on reset mid-run
      load(6'b111111);
      @(negedge clk) por_rst_n = 1'b0;
      step();
      chk("R1 re-clear", int'(state_o), 0);
      chk("R1 re-victim", int'(victim_o), 3);
      @(negedge clk) por_rst_n = 1'b1;
      step();

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule